// File: doc/BRIEF.md
# Control Interface Mode Selector

This block settles, once per reset, which control personality a device presents on its shared control pins. There are three: a two-wire bus slave, a four-wire serial slave, and a self-boot master that fetches its program, parameters and register settings from external memory. A boot-strap input decides between the two-wire default and self-boot. From the two-wire default, three low pulses on the latch/select pin move the device into four-wire mode.

Once the mode is known, the block steers the roles of the shared pins. It enables the clock pin as an output or leaves it as an input. It chooses open-drain or push-pull driving for the data pins. It routes the address/data pin either to the serial data input or to a writeback trigger. It also gives the downstream protocol engines a one-hot mode word and a single-cycle request to start the load from external memory.

Top module: `ctl_mode_select`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 3'b000 and every pin-role output and `load_req_o` is 0.
- R2: If `strap_boot_i` is 0 at the first rising clock edge with `rst_n` high, `mode_o` becomes 3'b001 (bit 0 = two-wire) at that edge.
- R3: If `strap_boot_i` is 1 at that edge, `mode_o` becomes 3'b100 (bit 2 = self-boot) and `load_req_o` is high for exactly that one following cycle.
- R4: Changes on `strap_boot_i` after that first edge have no effect on `mode_o`.
- R5: In two-wire mode, a high-to-low change of `latch_i` is counted when its first low sample at edge k follows a high sample at edge k-1. It is counted at edge k+2. The third counted fall sets `mode_o` to 3'b010 (bit 1 = four-wire) at that edge.
- R6: One or two counted falls leave `mode_o` at 3'b001.
- R7: Four-wire and self-boot modes hold until the next reset, whatever `latch_i` and `strap_boot_i` do. Falls of `latch_i` in self-boot are not counted.
- R8: The pin roles follow the mode. `clk_pin_oe_o` and `wp_od_en_o` are 1 only in self-boot. `data_od_en_o` is 1 in two-wire and self-boot. `dout_pp_en_o` and `sdi_sel_o` are 1 only in four-wire.
- R9: `wb_trig_o` equals `wb_pin_i` delayed through two synchronizer flops while in self-boot, and is 0 in every other mode.
- R10: After the deciding edge, exactly one bit of `mode_o` is set at all times until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_boot_i | input | 1 | Boot strap: 1 selects self-boot |
| latch_i | input | 1 | Latch/select pin, asynchronous |
| wb_pin_i | input | 1 | Address/writeback pin, asynchronous |
| mode_o | output | 3 | One-hot mode: bit0 two-wire, bit1 four-wire, bit2 self-boot |
| load_req_o | output | 1 | One-cycle request to load from external memory |
| clk_pin_oe_o | output | 1 | Clock pin driven as output |
| data_od_en_o | output | 1 | Data pin used as open-drain output |
| dout_pp_en_o | output | 1 | Data-out pin used as push-pull output |
| wp_od_en_o | output | 1 | Write-protect pin used as open-drain output |
| sdi_sel_o | output | 1 | Address/data pin routed to serial data input |
| wb_trig_o | output | 1 | Synchronized writeback trigger |

## Verification
A bad pulse count shows up on `mode_o`. A count that advances too early or too late moves the switch into four-wire off the expected edge, and a count that is lost keeps the device in two-wire after the third pulse. A wrong mode register also shows at once on the pin-role outputs, because each output is compared against the reference on every cycle. The comparison therefore catches the fault in the cycle where the design diverges. A fault in the boot-strap latch, or in the lock on the mode, appears as a mode change after a strap toggle or after latch pulses within a cycle of that stimulus.

// File: rtl/ctl_mode_pkg.sv
// Package: shared types for the control mode selector.
// Assumes: the four states fit in two bits; the one-hot word is three bits wide.
package ctl_mode_pkg;
    typedef enum logic [1:0] {
        ST_UNDEC = 2'd0,
        ST_BUS2W = 2'd1,
        ST_SER4W = 2'd2,
        ST_BOOT  = 2'd3
    } mode_state_t;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MW_BUS2W = 3'b001;
    localparam logic [MODE_W-1:0] MW_SER4W = 3'b010;
    localparam logic [MODE_W-1:0] MW_BOOT  = 3'b100;
endpackage

// File: rtl/cms_sync.sv
// Module: multi-flop synchronizer for one asynchronous pin.
// Assumes: STAGES >= 2; RST_VAL is the idle level of the pin.
module cms_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cms_fall_counter.sv
// Module: counts falling edges of a synchronized level while enabled.
// Assumes: the input is already synchronized and idles high; PULSES >= 1.
// hit_o is high during the cycle in which the last needed fall is seen.
module cms_fall_counter #(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(PULSES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt;
    logic             fall;

    assign fall  = lvl_q & ~lvl_i;
    assign hit_o = en_i & fall & (cnt == LAST);

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_i;
    end

    // Advance the fall count while counting is enabled, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt <= '0;
        else if (en_i && fall && cnt != LAST + 1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cms_mode_fsm.sv
// Module: mode decision state machine.
// Assumes: strap_i is static around reset release; hit_i comes from the fall counter.
// The strap is read only on the first edge after reset; the two terminal modes lock.
module cms_mode_fsm
    import ctl_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_i,
    input  logic        hit_i,
    output mode_state_t state_o,
    output logic        count_en_o,
    output logic        load_req_o
);
    mode_state_t state, state_nx;

    // Next-state choice: strap decides once, pulse count may promote two-wire.
    always_comb begin
        state_nx = state;
        case (state)
            ST_UNDEC: state_nx = strap_i ? ST_BOOT : ST_BUS2W;
            ST_BUS2W: if (hit_i) state_nx = ST_SER4W;
            default:  state_nx = state;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_UNDEC;
        else        state <= state_nx;
    end

    // One-cycle load request raised on entry into self-boot.
    always_ff @(posedge clk) begin
        if (!rst_n) load_req_o <= 1'b0;
        else        load_req_o <= (state == ST_UNDEC) && strap_i;
    end

    assign state_o    = state;
    assign count_en_o = (state == ST_BUS2W);
endmodule

// File: rtl/cms_pin_steer.sv
// Module: maps the mode state onto the one-hot word and the pin roles.
// Assumes: wb_s_i is the synchronized writeback pin.
module cms_pin_steer
    import ctl_mode_pkg::*;
(
    input  mode_state_t       state_i,
    input  logic              wb_s_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              clk_pin_oe_o,
    output logic              data_od_en_o,
    output logic              dout_pp_en_o,
    output logic              wp_od_en_o,
    output logic              sdi_sel_o,
    output logic              wb_trig_o
);
    logic is_bus, is_ser, is_boot;

    // Decode the state into per-mode flags and the one-hot word.
    always_comb begin
        is_bus  = (state_i == ST_BUS2W);
        is_ser  = (state_i == ST_SER4W);
        is_boot = (state_i == ST_BOOT);
        mode_o  = '0;
        if (is_bus)  mode_o = MW_BUS2W;
        if (is_ser)  mode_o = MW_SER4W;
        if (is_boot) mode_o = MW_BOOT;
    end

    // Pin direction and driver-type selection per mode.
    always_comb begin
        clk_pin_oe_o = is_boot;
        data_od_en_o = is_bus | is_boot;
        dout_pp_en_o = is_ser;
        wp_od_en_o   = is_boot;
        sdi_sel_o    = is_ser;
        wb_trig_o    = is_boot & wb_s_i;
    end
endmodule

// File: rtl/ctl_mode_select.sv
// Module: top of the control mode selector.
// Assumes: latch_i and wb_pin_i are asynchronous pins; strap_boot_i is a static strap.
// Chooses two-wire, four-wire or self-boot and steers the shared control pins.
module ctl_mode_select
    import ctl_mode_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SWITCH_PULSES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_boot_i,
    input  logic              latch_i,
    input  logic              wb_pin_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              load_req_o,
    output logic              clk_pin_oe_o,
    output logic              data_od_en_o,
    output logic              dout_pp_en_o,
    output logic              wp_od_en_o,
    output logic              sdi_sel_o,
    output logic              wb_trig_o
);
    logic        latch_s, wb_s, hit, count_en;
    mode_state_t state;

    cms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_latch_sync (
        .clk(clk), .rst_n(rst_n), .d_i(latch_i), .q_o(latch_s)
    );

    cms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wb_sync (
        .clk(clk), .rst_n(rst_n), .d_i(wb_pin_i), .q_o(wb_s)
    );

    cms_fall_counter #(.PULSES(SWITCH_PULSES)) u_count (
        .clk(clk), .rst_n(rst_n), .en_i(count_en), .lvl_i(latch_s), .hit_o(hit)
    );

    cms_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_boot_i), .hit_i(hit),
        .state_o(state), .count_en_o(count_en), .load_req_o(load_req_o)
    );

    cms_pin_steer u_steer (
        .state_i(state), .wb_s_i(wb_s), .mode_o(mode_o),
        .clk_pin_oe_o(clk_pin_oe_o), .data_od_en_o(data_od_en_o),
        .dout_pp_en_o(dout_pp_en_o), .wp_od_en_o(wp_od_en_o),
        .sdi_sel_o(sdi_sel_o), .wb_trig_o(wb_trig_o)
    );
endmodule

// File: rtl/ctl_mode_select_chk.sv
// Module: property checker for the mode selector, bound to the top.
// Assumes: reset is held for at least one clock at start.
module ctl_mode_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_o,
    input logic       load_req_o,
    input logic       data_od_en_o,
    input logic       dout_pp_en_o,
    input logic       wb_trig_o
);
    logic decided;

    // Track whether the deciding edge has already passed since reset.
    always_ff @(posedge clk) begin
        decided <= rst_n;
    end

    // R1
    undecided_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decided |-> (mode_o == 3'b000 && !load_req_o));

    // R10
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decided |-> ($countones(mode_o) == 1));

    // R7
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'b010 || mode_o == 3'b100) |=> $stable(mode_o));

    // R5
    bus_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'b001) |=> (mode_o == 3'b001 || mode_o == 3'b010));

    // R3
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |=> !load_req_o);

    // R3
    load_in_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> mode_o[2]);

    // R8
    driver_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_od_en_o && dout_pp_en_o));

    // R9
    wb_boot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_trig_o |-> mode_o[2]);
endmodule

bind ctl_mode_select ctl_mode_select_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .load_req_o(load_req_o),
    .data_od_en_o(data_od_en_o), .dout_pp_en_o(dout_pp_en_o), .wb_trig_o(wb_trig_o)
);

// File: tb/ctl_mode_select_test.sv
`timescale 1ns/1ps
module ctl_mode_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_boot_i = 1'b0;
    logic       latch_i = 1'b1;
    logic       wb_pin_i = 1'b0;
    logic [2:0] mode_o;
    logic       load_req_o, clk_pin_oe_o, data_od_en_o, dout_pp_en_o;
    logic       wp_od_en_o, sdi_sel_o, wb_trig_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    ctl_mode_select uut (
        .clk(clk), .rst_n(rst_n), .strap_boot_i(strap_boot_i), .latch_i(latch_i),
        .wb_pin_i(wb_pin_i), .mode_o(mode_o), .load_req_o(load_req_o),
        .clk_pin_oe_o(clk_pin_oe_o), .data_od_en_o(data_od_en_o),
        .dout_pp_en_o(dout_pp_en_o), .wp_od_en_o(wp_od_en_o),
        .sdi_sel_o(sdi_sel_o), .wb_trig_o(wb_trig_o)
    );

    always #2 clk = ~clk;

    // Behavioural reference: 0 undecided, 1 two-wire, 2 four-wire, 3 self-boot.
    int m = 0;
    int falls = 0;
    bit exp_load = 0;
    bit exp_wbs = 0;
    bit lq[$] = '{1'b1, 1'b1, 1'b1};
    bit wq[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        bit lnow, wnow, fall;
        lnow = rst_n ? latch_i : 1'b1;
        wnow = rst_n ? wb_pin_i : 1'b0;
        fall = (lq[lq.size()-3] == 1'b1) && (lq[lq.size()-2] == 1'b0);
        if (!rst_n) begin
            m = 0; falls = 0; exp_load = 0;
        end else begin
            exp_load = 0;
            case (m)
                0: begin m = strap_boot_i ? 3 : 1; exp_load = strap_boot_i; end
                1: if (fall) begin falls++; if (falls == 3) m = 2; end
                default: ;
            endcase
        end
        lq.push_back(lnow); wq.push_back(wnow);
        if (lq.size() > 8) void'(lq.pop_front());
        if (wq.size() > 8) void'(wq.pop_front());
        exp_wbs = wq[wq.size()-2];
    end

    function automatic logic [2:0] mode_word(int s);
        return (s == 1) ? 3'b001 : (s == 2) ? 3'b010 : (s == 3) ? 3'b100 : 3'b000;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every port against the reference away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R1/R2/R3/R5/R10 mode", {5'd0, mode_o}, {5'd0, mode_word(m)});
            chk("R3 load_req", {7'd0, load_req_o}, {7'd0, exp_load});
            chk("R8 clk_pin_oe", {7'd0, clk_pin_oe_o}, {7'd0, m == 3});
            chk("R8 data_od_en", {7'd0, data_od_en_o}, {7'd0, m == 1 || m == 3});
            chk("R8 dout_pp_en", {7'd0, dout_pp_en_o}, {7'd0, m == 2});
            chk("R8 wp_od_en", {7'd0, wp_od_en_o}, {7'd0, m == 3});
            chk("R8 sdi_sel", {7'd0, sdi_sel_o}, {7'd0, m == 2});
            chk("R9 wb_trig", {7'd0, wb_trig_o}, {7'd0, (m == 3) && exp_wbs});
        end
    end

    task automatic do_reset(bit strap);
        @(negedge clk); #0.5;
        rst_n = 1'b0; strap_boot_i = strap;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {5'd0, mode_o}, 8'd0);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(int lo, int hi);
        @(negedge clk); #0.5 latch_i = 1'b0;
        repeat (lo) @(negedge clk);
        #0.5 latch_i = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // Two-wire default, strap ignored, partial count, then four-wire.
        do_reset(1'b0);
        chk("R2 two-wire after strap low", {5'd0, mode_o}, 8'h01);
        #0.5 strap_boot_i = 1'b1;
        wait_cyc(4);
        chk("R4 strap ignored", {5'd0, mode_o}, 8'h01);
        pulse(1, 3);
        pulse(4, 5);
        wait_cyc(4);
        chk("R6 two falls stay two-wire", {5'd0, mode_o}, 8'h01);
        #0.5 wb_pin_i = 1'b1;
        wait_cyc(4);
        chk("R9 wb idle in two-wire", {7'd0, wb_trig_o}, 8'd0);
        pulse(2, 1);
        wait_cyc(3);
        chk("R5 third fall gives four-wire", {5'd0, mode_o}, 8'h02);
        pulse(1, 2); pulse(1, 2);
        #0.5 strap_boot_i = 1'b0;
        wait_cyc(4);
        chk("R7 four-wire locked", {5'd0, mode_o}, 8'h02);

        // Self-boot entry, lock and writeback trigger.
        #0.5 wb_pin_i = 1'b0;
        do_reset(1'b1);
        wait_cyc(2);
        chk("R3 self-boot mode", {5'd0, mode_o}, 8'h04);
        pulse(1, 2); pulse(1, 2); pulse(1, 2); pulse(2, 3);
        chk("R7 latch ignored in self-boot", {5'd0, mode_o}, 8'h04);
        #0.5 strap_boot_i = 1'b0;
        wait_cyc(3);
        chk("R4 strap ignored in self-boot", {5'd0, mode_o}, 8'h04);
        #0.5 wb_pin_i = 1'b1;
        wait_cyc(1);
        chk("R9 wb not yet through sync", {7'd0, wb_trig_o}, 8'd0);
        wait_cyc(2);
        chk("R9 wb through sync", {7'd0, wb_trig_o}, 8'd1);
        #0.5 wb_pin_i = 1'b0;
        wait_cyc(3);

        // Latch held low across reset release; slow pulses with long gaps.
        latch_i = 1'b0;
        do_reset(1'b0);
        wait_cyc(3);
        #0.5 latch_i = 1'b1;
        wait_cyc(3);
        chk("R6 first fall after reset", {5'd0, mode_o}, 8'h01);
        pulse(6, 10);
        chk("R6 two falls", {5'd0, mode_o}, 8'h01);
        pulse(1, 10);
        chk("R5 switch after slow pulses", {5'd0, mode_o}, 8'h02);

        // Reset returns from four-wire to a fresh decision.
        do_reset(1'b0);
        chk("R10 fresh two-wire after reset", {5'd0, mode_o}, 8'h01);
        pulse(1, 1); pulse(1, 1); pulse(1, 4);
        chk("R5 fast pulses switch", {5'd0, mode_o}, 8'h02);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule